// File: doc/BRIEF.md
# Micro-operation sequencer

This block is the control unit and register datapath of a small one-address accumulator machine. The instruction cycle is split into four phases (fetch, indirect, execute, interrupt), and every phase is a fixed, timed list of register transfers. The block steps through that list one group of transfers per clock. It holds a program counter, a memory address register, a memory buffer register, an instruction register and one working register (the accumulator).

The block drives a synchronous single-port word memory. It presents `mem_addr` (always the memory address register) and `mem_wdata` (always the memory buffer register), and it pulses `mem_rd` or `mem_wr` for one clock. Read data arrives on `mem_rdata` one cycle after the read strobe. Each read therefore takes two clocks: one strobe clock and one capture clock.

A level-sensitive `irq` is sampled at the end of each execute phase. If the interrupt-enable flag is set at that point, the block saves the program counter and jumps to a handler. A HALT opcode freezes the block until reset.

Top module: `uop_sequencer`

## Requirements
- R1: While reset is held and right after it, phase is 00, the program counter and the accumulator are 0, the interrupt-enable flag is 1, `halted` is 0, and neither memory strobe is asserted.
- R2: The phase code is 00 for fetch, 01 for indirect, 10 for execute and 11 for interrupt. The internal step count restarts at the first step on every phase change. The indirect phase is entered only for words whose indirect flag is set.
- R3: An instruction word has the indirect flag in bit 15, the opcode in bits 14:12 and the operand address in bits 11:0. The opcodes are 001 ADD, 010 ISZ, 011 BSA and 111 HALT.
- R4: A read strobe comes one clock after the clock that loads the address register. The word on `mem_rdata` in the next clock is what the buffer register captures. Read and write are never strobed in the same clock.
- R5: Fetch and ADD execute each take four clocks. A direct ADD, ADD, HALT program sets `halted` on the 21st clock edge after reset is released.
- R6: ADD adds the addressed word to the accumulator modulo 2^16.
- R7: With the indirect flag set, the operand address is replaced by bits 11:0 of the word read from the original address. Bits 15:12 of that pointer word are ignored.
- R8: ISZ writes the addressed word plus one back to memory. It skips the next instruction exactly when the written value is 0.
- R9: BSA X stores the address of the word that follows it into location X. Execution then continues at X+1.
- R10: Opcodes 000, 100, 101 and 110 change nothing except that the program counter moves past them.
- R11: Once halted, the block keeps `halted` set, holds the program counter, issues no strobes and ignores `irq`, until reset.
- R12: At the end of execute, if `irq` is high and interrupts are enabled, the block writes the program counter to SAVE_ADDR, jumps to HANDLER_ADDR and clears the enable flag. A later request is ignored while the flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Level-sensitive interrupt request |
| mem_addr | output | AW | Memory address (address register) |
| mem_wdata | output | AW+4 | Memory write data (buffer register) |
| mem_rd | output | 1 | Read strobe, data valid next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | AW+4 | Memory read data |
| phase | output | 2 | Current phase code |
| pc | output | AW | Program counter |
| r1 | output | AW+4 | Accumulator |
| int_en | output | 1 | Interrupt-enable flag |
| halted | output | 1 | HALT executed |

## Verification
The bench sweeps ADD over carry and sign boundary operands. A design that captured read data a clock early or late would return stale sums, and one with a step count off by one would miss the exact 21-edge halt time. ISZ is driven across the all-ones value, where a wrong skip test either runs the skipped ADD or skips on a non-zero result. BSA is tried at two call sites and two targets, so a return address off by one or a continuation at X instead of X+1 shows up in memory and in the accumulator. The indirect test puts junk in the pointer's top bits, a held request checks that the cleared enable blocks a second interrupt, and requests after HALT must leave the program counter and the strobes quiet.

// File: rtl/uop_sequencer.sv
module uop_sequencer #(
  parameter int AW = 12,
  parameter int unsigned SAVE_ADDR = 0,
  parameter int unsigned HANDLER_ADDR = 1,
  localparam int DW = AW + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [DW-1:0] mem_rdata,
  output logic [1:0]    phase,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] r1,
  output logic          int_en,
  output logic          halted
);
  localparam logic [1:0] PH_FETCH = 2'b00, PH_IND = 2'b01, PH_EXEC = 2'b10, PH_INT = 2'b11;
  localparam logic [2:0] OP_ADD = 3'b001, OP_ISZ = 3'b010, OP_BSA = 3'b011, OP_HALT = 3'b111;

  logic [1:0]    phase_q, phase_nx;
  logic [2:0]    step_q;
  logic [AW-1:0] pc_q, mar_q;
  logic [DW-1:0] mbr_q, r1_q;
  logic [DW-2:0] ir_q;
  logic          ie_q, halt_q, done;

  wire [2:0]    op      = ir_q[DW-2 -: 3];
  wire [AW-1:0] ir_addr = ir_q[AW-1:0];
  wire          rd_op   = (op == OP_ADD) || (op == OP_ISZ);

  assign mem_addr  = mar_q;
  assign mem_wdata = mbr_q;
  assign phase     = phase_q;
  assign pc        = pc_q;
  assign r1        = r1_q;
  assign int_en    = ie_q;
  assign halted    = halt_q;

  assign mem_rd = !halt_q && step_q == 3'd1 &&
                  (phase_q == PH_FETCH || phase_q == PH_IND || (phase_q == PH_EXEC && rd_op));
  assign mem_wr = !halt_q && ((phase_q == PH_INT && step_q == 3'd2) ||
                  (phase_q == PH_EXEC && op == OP_ISZ && step_q == 3'd4) ||
                  (phase_q == PH_EXEC && op == OP_BSA && step_q == 3'd1));

  always_comb begin
    done = 1'b0;
    phase_nx = PH_FETCH;
    case (phase_q)
      PH_FETCH: begin done = step_q == 3'd3; phase_nx = mbr_q[DW-1] ? PH_IND : PH_EXEC; end
      PH_IND:   begin done = step_q == 3'd3; phase_nx = PH_EXEC; end
      PH_INT:   begin done = step_q == 3'd2; phase_nx = PH_FETCH; end
      default: begin
        case (op)
          OP_ADD:  done = step_q == 3'd3;
          OP_ISZ:  done = step_q == 3'd4;
          OP_BSA:  done = step_q == 3'd2;
          OP_HALT: done = 1'b0;
          default: done = 1'b1;
        endcase
        phase_nx = (irq && ie_q) ? PH_INT : PH_FETCH;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
      step_q  <= '0;
      pc_q    <= '0;
      mar_q   <= '0;
      mbr_q   <= '0;
      ir_q    <= '0;
      r1_q    <= '0;
      ie_q    <= 1'b1;
      halt_q  <= 1'b0;
    end else if (!halt_q) begin
      step_q <= done ? 3'd0 : step_q + 3'd1;
      if (done) phase_q <= phase_nx;
      if (done && phase_q == PH_EXEC && phase_nx == PH_INT) ie_q <= 1'b0;
      case (phase_q)
        PH_FETCH: case (step_q)
          3'd0: mar_q <= pc_q;
          3'd2: begin mbr_q <= mem_rdata; pc_q <= pc_q + AW'(1); end
          3'd3: ir_q <= mbr_q[DW-2:0];
          default: ;
        endcase
        PH_IND: case (step_q)
          3'd0: mar_q <= ir_addr;
          3'd2: mbr_q <= mem_rdata;
          3'd3: ir_q[AW-1:0] <= mbr_q[AW-1:0];
          default: ;
        endcase
        PH_INT: case (step_q)
          3'd0: mbr_q <= DW'(pc_q);
          3'd1: begin mar_q <= AW'(SAVE_ADDR); pc_q <= AW'(HANDLER_ADDR); end
          default: ;
        endcase
        default: case (op)
          OP_ADD: case (step_q)
            3'd0: mar_q <= ir_addr;
            3'd2: mbr_q <= mem_rdata;
            3'd3: r1_q <= r1_q + mbr_q;
            default: ;
          endcase
          OP_ISZ: case (step_q)
            3'd0: mar_q <= ir_addr;
            3'd2: mbr_q <= mem_rdata;
            3'd3: mbr_q <= mbr_q + DW'(1);
            3'd4: if (mbr_q == '0) pc_q <= pc_q + AW'(1);
            default: ;
          endcase
          OP_BSA: case (step_q)
            3'd0: begin mar_q <= ir_addr; mbr_q <= DW'(pc_q); end
            3'd1: pc_q <= ir_addr;
            3'd2: pc_q <= pc_q + AW'(1);
            default: ;
          endcase
          OP_HALT: halt_q <= 1'b1;
          default: ;
        endcase
      endcase
    end
  end
endmodule

// File: rtl/uop_sequencer_chk.sv
module uop_sequencer_chk #(
  parameter int AW = 12,
  localparam int DW = AW + 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    phase,
  input logic [2:0]    step,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [DW-1:0] mem_rdata,
  input logic [DW-1:0] mbr,
  input logic [AW-1:0] pc,
  input logic          int_en,
  input logic          halted
);
  assert_rd_wr_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_read_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> ##1 (mbr == $past(mem_rdata)));

  assert_step_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase)) |-> (step == 3'd0));

  assert_halt_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc) && !mem_rd && !mem_wr));

  assert_int_clears_enable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b11 && $past(phase) != 2'b11) |-> !int_en);

  assert_int_from_execute_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b11 && $past(phase) != 2'b11) |-> ($past(phase) == 2'b10));
endmodule

bind uop_sequencer uop_sequencer_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .phase(phase_q), .step(step_q),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata),
  .mbr(mbr_q), .pc(pc_q), .int_en(ie_q), .halted(halt_q)
);

// File: tb/uop_sequencer_tb.sv
`timescale 1ns/1ps
module uop_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic [11:0] mem_addr, pc;
  logic [15:0] mem_wdata, mem_rdata, r1;
  logic        mem_rd, mem_wr, int_en, halted;
  logic [1:0]  phase;
  logic [15:0] mem [0:255];
  int checks = 0, errors = 0, strobes = 0, both = 0;
  bit seen_ind = 0, seen_int = 0, finished = 0;

  always #4 clk = ~clk;

  uop_sequencer #(.AW(12), .SAVE_ADDR(12'h080), .HANDLER_ADDR(12'h090)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq(irq), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata), .phase(phase), .pc(pc),
    .r1(r1), .int_en(int_en), .halted(halted));

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  end

  always @(negedge clk) if (rst_n) begin
    if (phase == 2'b01) seen_ind = 1;
    if (phase == 2'b11) seen_int = 1;
    if (mem_rd || mem_wr) strobes++;
    if (mem_rd && mem_wr) both++;
  end

  function automatic logic [15:0] ins(bit ind, logic [2:0] op, logic [11:0] a);
    return {ind, op, a};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic run(output int cyc);
    @(negedge clk) rst_n = 0;
    repeat (3) @(negedge clk);
    seen_ind = 0; seen_int = 0; both = 0;
    rst_n = 1;
    cyc = 0;
    while (!halted && cyc < 2000) begin
      @(posedge clk); #1;
      cyc++;
    end
    if (cyc >= 2000) chk("run timeout", cyc, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic [15:0] vals [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
    logic [15:0] iszv [5] = '{16'h0000, 16'h0001, 16'h7FFF, 16'hFFFE, 16'hFFFF};
    logic [15:0] ptrs [3] = '{16'h0060, 16'hF060, 16'h7060};
    logic [2:0]  nops [4] = '{3'b000, 3'b100, 3'b101, 3'b110};

    // R1 reset state
    clear_mem();
    repeat (3) @(negedge clk);
    chk("R1 phase", phase, 2'b00);
    chk("R1 pc", pc, 0);
    chk("R1 r1", r1, 0);
    chk("R1 int_en", int_en, 1);
    chk("R1 halted", halted, 0);
    chk("R1 strobes", {mem_rd, mem_wr}, 0);

    // R6 ADD sweep, R5 timing, R3 decode
    foreach (vals[a]) foreach (vals[b]) begin
      clear_mem();
      mem[0] = ins(0, 3'b001, 12'h040);
      mem[1] = ins(0, 3'b001, 12'h041);
      mem[2] = ins(0, 3'b111, 12'h000);
      mem[8'h40] = vals[a];
      mem[8'h41] = vals[b];
      run(cyc);
      chk("R6 add sum", r1, 16'(vals[a] + vals[b]));
      chk("R5 halt edge count", cyc, 21);
      chk("R3 pc after halt", pc, 3);
      chk("R2 no indirect phase", seen_ind, 0);
      chk("R4 no dual strobe", both, 0);
      chk("R12 enable kept", int_en, 1);
    end

    // R7 indirect, pointer high bits ignored
    foreach (ptrs[p]) begin
      clear_mem();
      mem[0] = ins(1, 3'b001, 12'h050);
      mem[1] = ins(0, 3'b111, 12'h000);
      mem[8'h50] = ptrs[p];
      mem[8'h60] = 16'h0ABC;
      run(cyc);
      chk("R7 indirect operand", r1, 16'h0ABC);
      chk("R2 indirect phase seen", seen_ind, 1);
      chk("R5 indirect edge count", cyc, 17);
    end

    // R8 ISZ sweep
    foreach (iszv[k]) begin
      logic [15:0] inc;
      inc = iszv[k] + 16'd1;
      clear_mem();
      mem[0] = ins(0, 3'b010, 12'h070);
      mem[1] = ins(0, 3'b001, 12'h071);
      mem[2] = ins(0, 3'b111, 12'h000);
      mem[8'h70] = iszv[k];
      mem[8'h71] = 16'h0001;
      run(cyc);
      chk("R8 isz writeback", mem[8'h70], inc);
      chk("R8 isz skip", r1, (inc == 0) ? 16'h0000 : 16'h0001);
      chk("R8 pc", pc, 3);
    end

    // R9 BSA with differing call sites and targets
    for (int n = 0; n < 4; n += 2) begin
      for (int t = 0; t < 2; t++) begin
        logic [11:0] x;
        x = (t == 0) ? 12'h020 : 12'h03C;
        clear_mem();
        for (int j = 0; j < n; j++) mem[j] = ins(0, 3'b101, 12'h000);
        mem[n] = ins(0, 3'b011, x);
        mem[x + 1] = ins(0, 3'b001, 12'h030);
        mem[x + 2] = ins(0, 3'b111, 12'h000);
        mem[8'h30] = 16'h0005;
        run(cyc);
        chk("R9 return address", mem[x[7:0]], 16'(n + 1));
        chk("R9 continue at X+1", r1, 16'h0005);
        chk("R9 pc", pc, 32'(x + 3));
      end
    end

    // R10 undefined opcodes
    foreach (nops[k]) begin
      clear_mem();
      mem[0] = ins(0, nops[k], 12'h040);
      mem[1] = ins(0, 3'b001, 12'h041);
      mem[2] = ins(0, 3'b111, 12'h000);
      mem[8'h40] = 16'h1111;
      mem[8'h41] = 16'h0002;
      run(cyc);
      chk("R10 no-op accumulator", r1, 16'h0002);
      chk("R10 no-op memory", mem[8'h40], 16'h1111);
      chk("R10 no-op pc", pc, 3);
    end

    // R11 halt freezes and ignores irq
    begin
      logic [11:0] pc0;
      pc0 = pc;
      @(negedge clk) irq = 1;
      strobes = 0;
      repeat (20) @(negedge clk);
      chk("R11 halted held", halted, 1);
      chk("R11 pc held", pc, pc0);
      chk("R11 no strobes", strobes, 0);
      chk("R11 irq ignored", int_en, 1);
    end

    // R12 interrupt entry, save, handler, enable cleared
    clear_mem();
    mem[0] = ins(0, 3'b001, 12'h040);
    mem[1] = ins(0, 3'b111, 12'h000);
    mem[8'h90] = ins(0, 3'b001, 12'h041);
    mem[8'h91] = ins(0, 3'b111, 12'h000);
    mem[8'h40] = 16'h0003;
    mem[8'h41] = 16'h0004;
    irq = 1;
    run(cyc);
    chk("R12 saved pc", mem[8'h80], 16'h0001);
    chk("R12 handler ran once", r1, 16'h0007);
    chk("R12 pc", pc, 12'h092);
    chk("R12 enable cleared", int_en, 0);
    chk("R2 interrupt phase seen", seen_int, 1);
    irq = 0;

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule